// File: doc/BRIEF.md
# Segmented Unit-Stride Load Sequencer

This block turns one segmented unit-stride vector load command into an ordered stream of micro-operations. A command carries a base address, a vector length in elements, an element-width code, an encoded field count, a register-group multiplier code, a destination register number and two status bits: vector unit enabled and invalid vector type. Each element of the load is a record of several fields laid out back to back in memory. The sequencer first issues memory-read micro-ops that bring raw interleaved records into internal staging registers. It then issues deinterleave micro-ops, each naming the architectural register it fills, the field it extracts and the chunk it belongs to.

The vector is cut into chunks of at most one register's worth of elements. Reads cover every chunk of every field before any deinterleave step starts. Both phases run with the field as the outer loop and the chunk as the inner loop. A zero-length command produces a single no-op. An illegal configuration produces a one-cycle flag and no micro-ops. Micro-ops leave on a valid/ready handshake, and a new command is taken only while the sequencer is idle.

Top module: `seg_load_seq`

## Requirements
- R1: Elements per register (epr) is VLEN/EEW, with EEW code 0, 1, 2, 3 meaning 8, 16, 32, 64 bits. The number of chunks (nch) is ceil(vl / epr).
- R2: A legal command with vl = 0 produces exactly one micro-op, of kind 0 (no-op), with first and last both set and an element count of 0.
- R3: A legal command with vl > 0 produces nfields × nch read micro-ops (kind 1) and then nfields × nch deinterleave micro-ops (kind 2). Within each phase, the chunk index steps fastest, field 0 comes first and chunk 0 comes first.
- R4: The element count of chunk i is min(vl − i × epr, epr). A read micro-op requests (EEW/8) × that count bytes. The byte count is 0 on other kinds.
- R5: The address of the read for chunk i of field f is base + bytes × (i + f × nch), modulo 2^ADDR_W. The address is 0 on other kinds.
- R6: The read for chunk i of field f fills staging register i + f × nch. The staging index is 0 on other kinds.
- R7: The deinterleave for chunk i of field f writes architectural register (vd + i + f × nch) mod 32. The register field is 0 on other kinds.
- R8: The first flag is set only on the first micro-op of a command, and the last flag only on its final one.
- R9: A command is illegal when the unit is disabled, when the invalid-type bit is set, when the multiplier code is 4 (reserved), or when a code c in 0..3 gives nfields × 2^c > 8. Fractional codes 5, 6 and 7 always pass the size test. An illegal command raises cmd_illegal for exactly the cycle after acceptance and produces no micro-op.
- R10: cmd_ready is high exactly while idle, so a command offered during a stream is not taken. The sequencer is idle again in the cycle after its last micro-op is accepted.
- R11: While uop_valid is high and uop_ready is low, every micro-op output holds its value.
- R12: The field count is the encoded nf value plus one, from 1 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken |
| cmd_base | input | ADDR_W | Base byte address |
| cmd_vl | input | VL_W | Vector length in elements |
| cmd_eew | input | 2 | Element width code |
| cmd_nf | input | 3 | Field count minus one |
| cmd_lmul | input | 3 | Register-group multiplier code |
| cmd_vd | input | 5 | First destination register |
| cmd_unit_en | input | 1 | Vector unit enabled |
| cmd_vill | input | 1 | Invalid vector type |
| cmd_illegal | output | 1 | One-cycle illegal-command flag |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Micro-op accepted |
| uop_kind | output | 2 | 0 no-op, 1 read, 2 deinterleave |
| uop_first | output | 1 | First micro-op of the command |
| uop_last | output | 1 | Final micro-op of the command |
| uop_addr | output | ADDR_W | Read address |
| uop_bytes | output | BYTE_W | Read size in bytes |
| uop_elems | output | VL_W | Elements in this chunk |
| uop_stage | output | IDX_W | Staging register index (reads) |
| uop_vd | output | 5 | Architectural register (deinterleaves) |
| uop_field | output | 3 | Field index |
| uop_chunk | output | VL_W | Chunk index |

## Verification
On every cycle the assertions check the handshake hold, that busy and idle exclude each other, that an illegal flag comes with no micro-op, and which fields each kind may drive. They also check that a stream opens with field 0, chunk 0 of the read phase, never falls back from deinterleave to read, and ends in idle. Exact addresses, element counts, staging and destination numbering, and total micro-op counts are shown only by the bench. It sweeps every width code and field count over lengths at and around chunk boundaries, and compares each accepted micro-op with a reference list rebuilt arithmetically. The illegal boundaries and the refusal of a command offered mid-stream are covered by dedicated scenarios.

// File: rtl/seg_seq_pkg.sv
package seg_seq_pkg;

  typedef enum logic [1:0] {
    UK_NOP   = 2'd0,
    UK_LOAD  = 2'd1,
    UK_DEINT = 2'd2
  } uop_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_NOP,
    PH_LOAD,
    PH_DEINT
  } walk_phase_e;

  // log2 of elements per register for a width code
  function automatic int unsigned lg_elems(int unsigned vlen_bits, logic [1:0] eew);
    return $clog2(vlen_bits) - 3 - {30'd0, eew};
  endfunction

  // chunks needed for vl elements at 2^lg per chunk
  function automatic int unsigned chunks_for(int unsigned vl, int unsigned lg);
    return (vl + (32'd1 << lg) - 32'd1) >> lg;
  endfunction

  // elements held by one chunk: full except the final one
  function automatic int unsigned chunk_len(int unsigned vl, int unsigned chunk,
                                            int unsigned last_chunk, int unsigned lg);
    if (chunk == last_chunk) return vl - (chunk << lg);
    return 32'd1 << lg;
  endfunction

  // field-major slot number
  function automatic int unsigned seg_slot(int unsigned chunk, int unsigned field,
                                           int unsigned nch);
    return chunk + field * nch;
  endfunction

  function automatic logic cfg_illegal(logic [2:0] lmul, int unsigned nfields,
                                       logic unit_en, logic vill);
    if (!unit_en || vill) return 1'b1;
    if (lmul == 3'd4) return 1'b1;
    if (lmul[2]) return 1'b0;
    return (nfields << lmul[1:0]) > 32'd8;
  endfunction

endpackage

// File: rtl/seg_cmd_decode.sv
module seg_cmd_decode
  import seg_seq_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int VL_W = 8
) (
  input  logic [VL_W-1:0] vl,
  input  logic [1:0]      eew,
  input  logic [2:0]      nf,
  input  logic [2:0]      lmul,
  input  logic            unit_en,
  input  logic            vill,
  output logic [VL_W-1:0] lg_epr,
  output logic [VL_W-1:0] nch_last,
  output logic            zero_len,
  output logic            illegal
);

  int unsigned lg_i;
  int unsigned nch_i;

  always_comb begin
    lg_i     = lg_elems(VLEN, eew);
    nch_i    = chunks_for(32'(vl), lg_i);
    lg_epr   = VL_W'(lg_i);
    nch_last = VL_W'(nch_i - 32'd1);
    zero_len = (vl == '0);
    illegal  = cfg_illegal(lmul, 32'(nf) + 32'd1, unit_en, vill);
  end

endmodule

// File: rtl/seg_walk_ctr.sv
module seg_walk_ctr
  import seg_seq_pkg::*;
#(
  parameter int VL_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_zero,
  input  logic            step,
  input  logic [2:0]      nf_code,
  input  logic [VL_W-1:0] nch_last,
  output walk_phase_e     phase,
  output logic [2:0]      field,
  output logic [VL_W-1:0] chunk,
  output logic            at_first,
  output logic            at_last
);

  logic chunk_end;
  logic field_end;

  assign chunk_end = (chunk == nch_last);
  assign field_end = (field == nf_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      field <= '0;
      chunk <= '0;
    end else if (start) begin
      phase <= start_zero ? PH_NOP : PH_LOAD;
      field <= '0;
      chunk <= '0;
    end else if (step) begin
      case (phase)
        PH_NOP: phase <= PH_IDLE;
        PH_LOAD, PH_DEINT: begin
          if (!chunk_end) begin
            chunk <= chunk + VL_W'(1);
          end else begin
            chunk <= '0;
            if (field_end) begin
              field <= '0;
              phase <= (phase == PH_LOAD) ? PH_DEINT : PH_IDLE;
            end else begin
              field <= field + 3'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    at_first = (phase == PH_NOP) ||
               (phase == PH_LOAD && field == '0 && chunk == '0);
    at_last  = (phase == PH_NOP) ||
               (phase == PH_DEINT && chunk_end && field_end);
  end

endmodule

// File: rtl/seg_uop_build.sv
module seg_uop_build
  import seg_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VL_W   = 8,
  parameter int IDX_W  = 11,
  parameter int BYTE_W = 5
) (
  input  walk_phase_e       phase,
  input  logic [2:0]        field,
  input  logic [VL_W-1:0]   chunk,
  input  logic [VL_W-1:0]   nch_last,
  input  logic [VL_W-1:0]   lg_epr,
  input  logic [1:0]        eew,
  input  logic [VL_W-1:0]   vl,
  input  logic [ADDR_W-1:0] base,
  input  logic [4:0]        vd,
  output logic [1:0]        kind,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] bytes,
  output logic [VL_W-1:0]   elems,
  output logic [IDX_W-1:0]  stage,
  output logic [4:0]        vd_out
);

  int unsigned slot_i;
  int unsigned len_i;
  int unsigned bytes_i;
  logic        is_load;
  logic        is_deint;

  always_comb begin
    is_load  = (phase == PH_LOAD);
    is_deint = (phase == PH_DEINT);
    slot_i   = seg_slot(32'(chunk), 32'(field), 32'(nch_last) + 32'd1);
    len_i    = chunk_len(32'(vl), 32'(chunk), 32'(nch_last), 32'(lg_epr));
    bytes_i  = len_i << eew;

    case (phase)
      PH_LOAD:  kind = UK_LOAD;
      PH_DEINT: kind = UK_DEINT;
      default:  kind = UK_NOP;
    endcase

    elems  = (is_load || is_deint) ? VL_W'(len_i) : '0;
    bytes  = is_load ? BYTE_W'(bytes_i) : '0;
    addr   = is_load ? base + ADDR_W'(bytes_i * slot_i) : '0;
    stage  = is_load ? IDX_W'(slot_i) : '0;
    vd_out = is_deint ? 5'(32'(vd) + slot_i) : '0;
  end

endmodule

// File: rtl/seg_load_seq.sv
module seg_load_seq
  import seg_seq_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int VLEN   = 128,
  localparam int VL_W   = $clog2(VLEN) + 1,
  localparam int IDX_W  = VL_W + 3,
  localparam int BYTE_W = $clog2(VLEN / 8) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [VL_W-1:0]   cmd_vl,
  input  logic [1:0]        cmd_eew,
  input  logic [2:0]        cmd_nf,
  input  logic [2:0]        cmd_lmul,
  input  logic [4:0]        cmd_vd,
  input  logic              cmd_unit_en,
  input  logic              cmd_vill,
  output logic              cmd_illegal,
  output logic              uop_valid,
  input  logic              uop_ready,
  output logic [1:0]        uop_kind,
  output logic              uop_first,
  output logic              uop_last,
  output logic [ADDR_W-1:0] uop_addr,
  output logic [BYTE_W-1:0] uop_bytes,
  output logic [VL_W-1:0]   uop_elems,
  output logic [IDX_W-1:0]  uop_stage,
  output logic [4:0]        uop_vd,
  output logic [2:0]        uop_field,
  output logic [VL_W-1:0]   uop_chunk
);

  // decoded view of the offered command
  logic [VL_W-1:0] dec_lg;
  logic [VL_W-1:0] dec_nch_last;
  logic            dec_zero;
  logic            dec_illegal;

  // latched command
  logic [ADDR_W-1:0] base_q;
  logic [VL_W-1:0]   vl_q;
  logic [1:0]        eew_q;
  logic [2:0]        nf_q;
  logic [4:0]        vd_q;
  logic [VL_W-1:0]   lg_q;
  logic [VL_W-1:0]   nch_last_q;
  logic              illegal_q;

  walk_phase_e       phase;

  // named events for the checker
  logic ev_cmd_take;
  logic ev_uop_take;
  logic ev_start;

  assign cmd_ready   = (phase == PH_IDLE);
  assign uop_valid   = (phase != PH_IDLE);
  assign ev_cmd_take = cmd_valid && cmd_ready;
  assign ev_uop_take = uop_valid && uop_ready;
  assign ev_start    = ev_cmd_take && !dec_illegal;
  assign cmd_illegal = illegal_q;

  seg_cmd_decode #(.VLEN(VLEN), .VL_W(VL_W)) u_decode (
    .vl       (cmd_vl),
    .eew      (cmd_eew),
    .nf       (cmd_nf),
    .lmul     (cmd_lmul),
    .unit_en  (cmd_unit_en),
    .vill     (cmd_vill),
    .lg_epr   (dec_lg),
    .nch_last (dec_nch_last),
    .zero_len (dec_zero),
    .illegal  (dec_illegal)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      vl_q       <= '0;
      eew_q      <= '0;
      nf_q       <= '0;
      vd_q       <= '0;
      lg_q       <= '0;
      nch_last_q <= '0;
      illegal_q  <= 1'b0;
    end else begin
      illegal_q <= ev_cmd_take && dec_illegal;
      if (ev_start) begin
        base_q     <= cmd_base;
        vl_q       <= cmd_vl;
        eew_q      <= cmd_eew;
        nf_q       <= cmd_nf;
        vd_q       <= cmd_vd;
        lg_q       <= dec_lg;
        nch_last_q <= dec_nch_last;
      end
    end
  end

  seg_walk_ctr #(.VL_W(VL_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ev_start),
    .start_zero (dec_zero),
    .step       (ev_uop_take),
    .nf_code    (nf_q),
    .nch_last   (nch_last_q),
    .phase      (phase),
    .field      (uop_field),
    .chunk      (uop_chunk),
    .at_first   (uop_first),
    .at_last    (uop_last)
  );

  seg_uop_build #(
    .ADDR_W (ADDR_W),
    .VL_W   (VL_W),
    .IDX_W  (IDX_W),
    .BYTE_W (BYTE_W)
  ) u_build (
    .phase    (phase),
    .field    (uop_field),
    .chunk    (uop_chunk),
    .nch_last (nch_last_q),
    .lg_epr   (lg_q),
    .eew      (eew_q),
    .vl       (vl_q),
    .base     (base_q),
    .vd       (vd_q),
    .kind     (uop_kind),
    .addr     (uop_addr),
    .bytes    (uop_bytes),
    .elems    (uop_elems),
    .stage    (uop_stage),
    .vd_out   (uop_vd)
  );

endmodule

// File: rtl/seg_load_seq_chk.sv
module seg_load_seq_chk
  import seg_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VL_W   = 8,
  parameter int IDX_W  = 11,
  parameter int BYTE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              cmd_illegal,
  input logic              ev_cmd_take,
  input logic              ev_uop_take,
  input logic              uop_valid,
  input logic              uop_ready,
  input logic [1:0]        uop_kind,
  input logic              uop_first,
  input logic              uop_last,
  input logic [ADDR_W-1:0] uop_addr,
  input logic [BYTE_W-1:0] uop_bytes,
  input logic [VL_W-1:0]   uop_elems,
  input logic [IDX_W-1:0]  uop_stage,
  input logic [4:0]        uop_vd,
  input logic [2:0]        uop_field,
  input logic [VL_W-1:0]   uop_chunk
);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid &&
      $stable({uop_kind, uop_first, uop_last, uop_addr, uop_bytes, uop_elems,
               uop_stage, uop_vd, uop_field, uop_chunk}));

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> !cmd_ready);

  p_take_only_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_take |-> !uop_valid);

  p_back_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_uop_take && uop_last |=> cmd_ready && !uop_valid);

  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_illegal |-> !uop_valid && cmd_ready);

  p_nop_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_kind == UK_NOP |-> uop_first && uop_last && uop_elems == '0);

  p_open_with_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_first && uop_kind != UK_NOP |->
      uop_kind == UK_LOAD && uop_field == '0 && uop_chunk == '0);

  p_no_load_after_deint_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_uop_take && uop_kind == UK_DEINT && !uop_last |=> uop_kind == UK_DEINT);

  p_last_not_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_last |-> uop_kind != UK_LOAD);

  p_stage_load_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_kind != UK_LOAD |-> uop_stage == '0 && uop_bytes == '0 &&
      uop_addr == '0);

  p_vd_deint_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_kind != UK_DEINT |-> uop_vd == '0);

endmodule

bind seg_load_seq seg_load_seq_chk #(
  .ADDR_W (ADDR_W),
  .VL_W   (VL_W),
  .IDX_W  (IDX_W),
  .BYTE_W (BYTE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_ready   (cmd_ready),
  .cmd_illegal (cmd_illegal),
  .ev_cmd_take (ev_cmd_take),
  .ev_uop_take (ev_uop_take),
  .uop_valid   (uop_valid),
  .uop_ready   (uop_ready),
  .uop_kind    (uop_kind),
  .uop_first   (uop_first),
  .uop_last    (uop_last),
  .uop_addr    (uop_addr),
  .uop_bytes   (uop_bytes),
  .uop_elems   (uop_elems),
  .uop_stage   (uop_stage),
  .uop_vd      (uop_vd),
  .uop_field   (uop_field),
  .uop_chunk   (uop_chunk)
);

// File: tb/seg_load_seq_test.sv
`timescale 1ns/1ps
module seg_load_seq_test;

  localparam int ADDR_W = 32;
  localparam int VLEN   = 64;
  localparam int VL_W   = 7;
  localparam int IDX_W  = 10;
  localparam int BYTE_W = 4;
  localparam int EPR8   = VLEN / 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [ADDR_W-1:0] cmd_base = '0;
  logic [VL_W-1:0]   cmd_vl = '0;
  logic [1:0]        cmd_eew = '0;
  logic [2:0]        cmd_nf = '0;
  logic [2:0]        cmd_lmul = '0;
  logic [4:0]        cmd_vd = '0;
  logic              cmd_unit_en = 1'b1;
  logic              cmd_vill = 1'b0;
  logic              cmd_illegal;
  logic              uop_valid;
  logic              uop_ready = 1'b0;
  logic [1:0]        uop_kind;
  logic              uop_first;
  logic              uop_last;
  logic [ADDR_W-1:0] uop_addr;
  logic [BYTE_W-1:0] uop_bytes;
  logic [VL_W-1:0]   uop_elems;
  logic [IDX_W-1:0]  uop_stage;
  logic [4:0]        uop_vd;
  logic [2:0]        uop_field;
  logic [VL_W-1:0]   uop_chunk;

  always #4 clk = ~clk;

  seg_load_seq #(.ADDR_W(ADDR_W), .VLEN(VLEN)) uut (.*);

  typedef struct {
    int unsigned kind, first, last, bytes, elems, stage, vd, field, chunk;
    longint unsigned addr;
  } exp_t;

  exp_t ex[512];
  int   n_ex;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string tag,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input longint unsigned act,
                        input longint unsigned exp);
    chk(act == exp, tag, act, exp);
  endtask

  // reference list, computed from the requirements
  task automatic build_expected(input longint unsigned base, input int vl,
                                input int eew, input int nf, input int vd);
    int epr, nch, nfl;
    n_ex = 0;
    if (vl == 0) begin
      ex[0] = '{kind: 0, first: 1, last: 1, bytes: 0, elems: 0, stage: 0,
                vd: 0, field: 0, chunk: 0, addr: 0};
      n_ex = 1;
      return;
    end
    epr = EPR8 >> eew;
    nch = (vl + epr - 1) / epr;
    nfl = nf + 1;
    for (int pass = 0; pass < 2; pass++)
      for (int f = 0; f < nfl; f++)
        for (int i = 0; i < nch; i++) begin
          int rem, el, slot;
          rem  = vl - i * epr;
          el   = (rem < epr) ? rem : epr;
          slot = i + f * nch;
          ex[n_ex].kind  = (pass == 0) ? 1 : 2;
          ex[n_ex].elems = el;
          ex[n_ex].field = f;
          ex[n_ex].chunk = i;
          ex[n_ex].first = 0;
          ex[n_ex].last  = 0;
          if (pass == 0) begin
            ex[n_ex].bytes = el * (1 << eew);
            ex[n_ex].addr  = (base + longint'(el * (1 << eew)) * slot) & 64'hFFFF_FFFF;
            ex[n_ex].stage = slot;
            ex[n_ex].vd    = 0;
          end else begin
            ex[n_ex].bytes = 0;
            ex[n_ex].addr  = 0;
            ex[n_ex].stage = 0;
            ex[n_ex].vd    = (vd + slot) % 32;
          end
          n_ex++;
        end
    ex[0].first = 1;
    ex[n_ex-1].last = 1;
  endtask

  task automatic drive_cmd(input longint unsigned base, input int vl, input int eew,
                           input int nf, input int vd, input int lmul,
                           input bit en, input bit vill);
    cmd_base    = ADDR_W'(base);
    cmd_vl      = VL_W'(vl);
    cmd_eew     = 2'(eew);
    cmd_nf      = 3'(nf);
    cmd_vd      = 5'(vd);
    cmd_lmul    = 3'(lmul);
    cmd_unit_en = en;
    cmd_vill    = vill;
  endtask

  task automatic issue(input longint unsigned base, input int vl, input int eew,
                       input int nf, input int vd, input int lmul,
                       input bit en, input bit vill);
    @(negedge clk);
    chk_eq("R10 ready while idle", cmd_ready, 1);
    drive_cmd(base, vl, eew, nf, vd, lmul, en, vill);
    cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic run_stream();
    int k = 0;
    bit stalled = 1'b0;
    logic [71:0] snap = '0;
    logic [71:0] cur;
    while (k < n_ex) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      uop_ready = lf[0] | lf[3];
      cur = {uop_kind, uop_first, uop_last, uop_addr, uop_bytes, uop_elems,
             uop_stage, uop_vd, uop_field, uop_chunk};
      if (stalled) chk(cur == snap, "R11 hold under back-pressure", cur[63:0], snap[63:0]);
      chk_eq("R3 valid during stream", uop_valid, 1);
      if (uop_valid) begin
        chk_eq("R10 not ready while busy", cmd_ready, 0);
        if (uop_ready) begin
          chk_eq("R2 R3 kind",              uop_kind,  ex[k].kind);
          chk_eq("R8 first flag",           uop_first, ex[k].first);
          chk_eq("R8 last flag",            uop_last,  ex[k].last);
          chk_eq("R5 address",              uop_addr,  ex[k].addr);
          chk_eq("R4 bytes",                uop_bytes, ex[k].bytes);
          chk_eq("R1 R4 elements",          uop_elems, ex[k].elems);
          chk_eq("R6 staging index",        uop_stage, ex[k].stage);
          chk_eq("R7 destination register", uop_vd,    ex[k].vd);
          chk_eq("R12 R3 field",            uop_field, ex[k].field);
          chk_eq("R1 R3 chunk",             uop_chunk, ex[k].chunk);
          k++;
          stalled = 1'b0;
        end else begin
          stalled = 1'b1;
          snap = cur;
        end
      end else begin
        k = n_ex;
      end
    end
    @(negedge clk);
    uop_ready = 1'b0;
    chk_eq("R10 idle after last accept", {uop_valid, cmd_ready}, 2'b01);
  endtask

  task automatic legal(input longint unsigned base, input int vl, input int eew,
                       input int nf, input int vd, input int lmul);
    build_expected(base, vl, eew, nf, vd);
    issue(base, vl, eew, nf, vd, lmul, 1'b1, 1'b0);
    run_stream();
  endtask

  task automatic illegal_case(input int nf, input int lmul, input bit en,
                              input bit vill, input string tag);
    issue(64'h40, 5, 0, nf, 1, lmul, en, vill);
    @(negedge clk);
    chk_eq({"R9 flag raised ", tag}, cmd_illegal, 1);
    chk_eq({"R9 no micro-op ", tag}, uop_valid, 0);
    @(negedge clk);
    chk_eq({"R9 flag one cycle ", tag}, {cmd_illegal, uop_valid, cmd_ready}, 3'b001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_eq("R10 reset state", {cmd_ready, uop_valid, cmd_illegal}, 3'b100);
    rst_n = 1'b1;

    // sweep widths, field counts and lengths around chunk boundaries
    for (int eew = 0; eew < 4; eew++)
      for (int nf = 0; nf < 8; nf++)
        for (int vc = 0; vc < 6; vc++) begin
          int epr, vl;
          epr = EPR8 >> eew;
          case (vc)
            0: vl = 0;
            1: vl = 1;
            2: vl = epr;
            3: vl = epr + 1;
            4: vl = 3 * epr - 1;
            default: vl = 4 * epr;
          endcase
          legal(64'h1000 * (vc + 1) + nf * 16, vl, eew, nf,
                (eew * 8 + nf * 3 + vc) % 32, 0);
        end

    // long streams, register and address wrap
    legal(64'h2000, 64, 0, 7, 5, 0);
    legal(64'h3000, 64, 3, 1, 30, 0);
    legal(64'hFFFF_FFF8, 9, 2, 2, 30, 0);

    // size-test boundaries (R9)
    legal(64'h500, 3, 2, 1, 4, 2);   // 2 fields x 4 = 8, legal
    legal(64'h600, 2, 1, 0, 8, 3);   // 1 field x 8 = 8, legal
    legal(64'h700, 3, 0, 7, 9, 7);   // fractional group, 8 fields, legal
    illegal_case(2, 2, 1'b1, 1'b0, "3 fields x 4");
    illegal_case(1, 3, 1'b1, 1'b0, "2 fields x 8");
    illegal_case(0, 4, 1'b1, 1'b0, "reserved code");
    illegal_case(0, 0, 1'b0, 1'b0, "unit disabled");
    illegal_case(0, 0, 1'b1, 1'b1, "invalid type");
    legal(64'h800, 4, 0, 1, 2, 0);   // normal service after illegal ones

    // command offered mid-stream is not taken (R10)
    build_expected(64'h900, 12, 0, 1, 3);
    issue(64'h900, 12, 0, 1, 3, 0, 1'b1, 1'b0);
    @(negedge clk);
    uop_ready = 1'b0;
    drive_cmd(64'hABC0, 0, 3, 6, 20, 0, 1'b1, 1'b0);
    cmd_valid = 1'b1;
    chk_eq("R10 busy refuses command", cmd_ready, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    run_stream();
    @(negedge clk);
    chk_eq("R10 offered command dropped", uop_valid, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule